// File: doc/BRIEF.md
# Joypad Group-Select Register

This block is the button-port register that a processor core of a small handheld console reads to poll its eight buttons. The buttons form two groups of four: an action group (A, B, Select, Start) and a direction group (Right, Left, Up, Down). Writing the register stores its upper nibble. Bits 4 and 5 of that nibble decide which group drives the lower nibble of the next read. A read returns the stored upper nibble with the selected buttons in the lower nibble. The lower nibble is active-low, so a pressed button reads 0.

The button levels are already debounced when they arrive. Each one passes through a flop synchronizer chain before it reaches the read path. The lower nibble is never stored: it is formed from the synchronized levels when a read strobe arrives, and the result is held on the output until the next read strobe.

Top module: `joypad_select_reg`

## Requirements
- R1: After reset the stored upper nibble is 0 and `rd_data` is 0x0F.
- R2: A write (`wr_en` high at a rising edge) stores `wr_data[7:4]`. The bits `wr_data[3:0]` have no effect on any later read value.
- R3: With stored bit 4 set and bit 5 clear, a read returns A, B, Select and Start, taken from `btn_action[0]`, `[1]`, `[2]` and `[3]`, in data bits 0 to 3. Each bit is 0 when its button is pressed, and `btn_dir` has no effect.
- R4: With stored bit 5 set and bit 4 clear, a read returns Right, Left, Up and Down, taken from `btn_dir[0]`, `[1]`, `[2]` and `[3]`, in data bits 0 to 3. Each bit is 0 when its button is pressed, and `btn_action` has no effect.
- R5: With both bits 4 and 5 set, each lower bit reads 0 if either group's button at that position is pressed.
- R6: With bits 4 and 5 both clear, the lower nibble reads 0xF whatever the buttons are.
- R7: `rd_data` changes only at a rising edge where `rd_en` is high. At that edge it takes the stored upper nibble in bits 7:4 and the button nibble in bits 3:0. At all other edges it holds its value.
- R8: With the default SYNC_STAGES of 2, a button level that changes before rising edge k shows up in a read taken at edge k+2, but not in a read taken at edge k+1.
- R9: When a write and a read fall on the same edge, the read returns the upper nibble stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; only bits 7:4 are kept |
| rd_en | input | 1 | Register read strobe |
| btn_action | input | 4 | Action group levels, 1 = pressed (A, B, Select, Start) |
| btn_dir | input | 4 | Direction group levels, 1 = pressed (Right, Left, Up, Down) |
| rd_data | output | 8 | Value captured by the last read |

## Verification
The bench builds the block with the default two-stage synchronizer. With that depth, the one-cycle boundary between a read that misses a fresh press and the next read that catches it falls at a fixed, known edge. The bench drives every select combination, including upper nibbles whose spare bits 6 and 7 are set, against patterns where the unselected group is fully pressed. This shows that the masking is done per group and not by accident.

// File: rtl/joypad_select_reg.sv
module joypad_select_reg #(
  parameter int SYNC_STAGES = 2,
  localparam int GRP = 4,
  localparam int KEYS = 2 * GRP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            rd_en,
  input  logic [GRP-1:0]  btn_action,
  input  logic [GRP-1:0]  btn_dir,
  output logic [7:0]      rd_data
);

  logic [GRP-1:0] sel_q;
  logic [KEYS-1:0] sync_q [SYNC_STAGES];
  logic [GRP-1:0] act_s, dir_s, pressed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= {btn_dir, btn_action};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign act_s   = sync_q[SYNC_STAGES-1][GRP-1:0];
  assign dir_s   = sync_q[SYNC_STAGES-1][KEYS-1:GRP];
  assign pressed = ({GRP{sel_q[0]}} & act_s) | ({GRP{sel_q[1]}} & dir_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_data[7:4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 8'h0F;
    else if (rd_en) rd_data <= {sel_q, ~pressed};
  end

  // R2
  store_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sel_q == $past(wr_data[7:4]));

  // R3
  action_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_q[1:0] == 2'b01) |=> rd_data[3:0] == ~$past(act_s));

  // R6
  none_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_q[1:0] == 2'b00) |=> rd_data[3:0] == 4'hF);

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R9
  read_old_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> rd_data[7:4] == $past(sel_q));

endmodule

// File: tb/test_joypad_select_reg.sv
module test_joypad_select_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] btn_action = '0;
  logic [3:0] btn_dir = '0;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  joypad_select_reg i_joypad_select_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .btn_action(btn_action), .btn_dir(btn_dir), .rd_data(rd_data)
  );

  // {write value, action, dir, expected read}
  localparam logic [23:0] VEC [10] = '{
    {8'h10, 4'b0001, 4'b0000, 8'h1E},  // R3
    {8'h10, 4'b1010, 4'b1111, 8'h15},  // R3
    {8'h20, 4'b1111, 4'b0100, 8'h2B},  // R4
    {8'h20, 4'b0000, 4'b1001, 8'h26},  // R4
    {8'h30, 4'b0001, 4'b1000, 8'h36},  // R5
    {8'h30, 4'b0011, 4'b0110, 8'h38},  // R5
    {8'h00, 4'b1111, 4'b1111, 8'h0F},  // R6
    {8'hC5, 4'b1111, 4'b1111, 8'hCF},  // R2 R6
    {8'hDF, 4'b0100, 4'b1111, 8'hDB},  // R2 R3
    {8'hE0, 4'b1111, 4'b0010, 8'hED}   // R4
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: rd_data=0x%02h expected completion", rd_data);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", rd_data, 8'h0F);
    rst_n = 1'b1;
    btn_action = 4'hF; btn_dir = 4'hF;
    settle();
    do_read();
    check("R1 read after reset", rd_data, 8'h0F);

    foreach (VEC[i]) begin
      do_write(VEC[i][23:16]);
      btn_action = VEC[i][15:12];
      btn_dir    = VEC[i][11:8];
      settle();
      do_read();
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), rd_data, VEC[i][7:0]);
    end

    // R7: no read strobe, output must hold while buttons and register change
    do_write(8'h10);
    btn_action = 4'b0000;
    settle();
    do_read();
    check("R7 baseline", rd_data, 8'h1F);
    btn_action = 4'b1111;
    do_write(8'h30);
    repeat (5) @(negedge clk);
    check("R7 hold without rd_en", rd_data, 8'h1F);

    // R8: synchronizer latency boundary
    do_write(8'h10);
    btn_action = 4'b0000;
    settle();
    do_read();
    check("R8 before press", rd_data, 8'h1F);
    @(negedge clk); btn_action = 4'b0001;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk);
    check("R8 read one edge after settle edge misses press", rd_data, 8'h1F);
    @(negedge clk); rd_en = 1'b0;
    check("R8 read at second edge sees press", rd_data, 8'h1E);

    // R9: same-edge write and read
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h20; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R9 read returns old upper nibble", rd_data, 8'h1E);
    btn_dir = 4'b1000;
    settle();
    do_read();
    check("R9 next read returns new upper nibble", rd_data, 8'h27);

    // R1: reset in the middle of operation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", rd_data, 8'h0F);
    rst_n = 1'b1;
    settle();
    do_read();
    check("R1 select cleared by reset", rd_data, 8'h0F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule